// File: doc/BRIEF.md
# Dual-Channel Converter Front-End Controller

This block is the digital side of a two-channel digital-to-analog converter attached to a host's parallel output channel. When the host pulses a function strobe, the block captures a control address word and compares it with two configured channel addresses. On a match it raises a data request. It then waits for the host to return a data word together with an acknowledge. The accepted word is split into two subchannel holding registers for the addressed channel, and the request is withdrawn.

Each holding register holds a sign flag and a 12-bit magnitude. A mode input chooses between trigonometric operation and linear operation. In trigonometric mode, subchannel 1 holds a sine code and subchannel 2 holds a cosine code, and the two sign flags together name the quadrant of the angle. In linear mode, each subchannel is an independent signed value. For every subchannel, the block also decodes a reference-select code that the analog switches use.

Top module: `dac_front_ctl`

## Requirements
- R1: A synchronous reset clears all four holding registers to zero (zero code, positive sign) and holds `dataReq` low.
- R2: A control address that appears without an `efStrobe` pulse never raises `dataReq`.
- R3: `efStrobe` is sampled at a clock edge. If the captured address equals `chanAAddr` or `chanBAddr`, `dataReq` is high after the second following edge. Any other address leaves `dataReq` low.
- R4: An `outAck` sampled high while `dataReq` is high loads the word, and `dataReq` is low after that same edge. An `outAck` while no request is pending changes nothing.
- R5: `dataWord[25:13]` goes to subchannel 1 and `dataWord[12:0]` goes to subchannel 2. Bit 12 of each 13-bit field is the sign flag (1 = negative), and bits 11:0 are the code. Register outputs use the same layout.
- R6: An accepted word is written only to the addressed channel. The other channel's registers are unchanged.
- R7: An `efStrobe` that arrives while an address is being checked or a request is pending is ignored. The pending transfer still completes into the channel that was first addressed, and no extra request follows.
- R8: With `trigMode`=1, the quadrant code is computed from the sine sign s (subchannel 1) and the cosine sign c (subchannel 2): s=0,c=0 gives 0; s=0,c=1 gives 1; s=1,c=1 gives 2; s=1,c=0 gives 3.
- R9: With `trigMode`=0, both quadrant outputs are 0. For every subchannel, the reference select is {trigMode, sign}. Bits [1:0] of `xRefSel` belong to subchannel 1 and bits [3:2] to subchannel 2.
- R10: If both channel addresses are equal, a matching word is written to channel A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| efStrobe | input | 1 | Function strobe that starts address processing |
| ctlWord | input | ADDR_W | Control address word |
| chanAAddr | input | ADDR_W | Configured address of channel A |
| chanBAddr | input | ADDR_W | Configured address of channel B |
| outAck | input | 1 | Host acknowledge with valid data |
| dataWord | input | 26 | Two sign-plus-code fields |
| trigMode | input | 1 | 1 = trigonometric, 0 = linear |
| dataReq | output | 1 | Request for a data word |
| aSub1 | output | 13 | Channel A subchannel 1 register |
| aSub2 | output | 13 | Channel A subchannel 2 register |
| bSub1 | output | 13 | Channel B subchannel 1 register |
| bSub2 | output | 13 | Channel B subchannel 2 register |
| aQuad | output | 2 | Channel A quadrant code |
| bQuad | output | 2 | Channel B quadrant code |
| aRefSel | output | 4 | Channel A reference selects |
| bRefSel | output | 4 | Channel B reference selects |

## Verification
The bench checks these corner cases, each against a faulty design it would catch:
- **Acknowledge while idle.** A design that lets this through corrupts a holding register.
- **Second strobe during a pending request.** A design that does not ignore it sends the data to the wrong channel or issues a duplicate request.
- **Unmatched address.** A design that responds to it raises a request that no transfer will ever answer.
- **Both addresses equal.** This exposes a priority error.

It also steps through all four sign combinations in trigonometric mode, then switches to linear mode. This catches a swapped quadrant table, or a decode that ignores the mode.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
  localparam int CODE_W  = 12;
  localparam int FIELD_W = CODE_W + 1;
  localparam int WORD_W  = 2 * FIELD_W;

  typedef enum logic [1:0] {
    IDLE       = 2'd0,
    ADDR_CHECK = 2'd1,
    REQUEST    = 2'd2,
    LOAD       = 2'd3
  } hsState_t;

  typedef struct packed {
    logic captAddr;
    logic loadA;
    logic loadB;
  } dpCtl_t;
endpackage

// File: rtl/dac_front_hs.sv
module dac_front_hs
  import dac_front_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   efStrobe,
  input  logic   outAck,
  input  logic   hitA,
  input  logic   hitB,
  output dpCtl_t ctl,
  output logic   dataReq
);
  hsState_t state;
  logic     selB;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= IDLE;
      selB  <= 1'b0;
    end else begin
      case (state)
        IDLE:       if (efStrobe) state <= ADDR_CHECK;
        ADDR_CHECK: begin
          if (hitA) begin
            state <= REQUEST;
            selB  <= 1'b0;
          end else if (hitB) begin
            state <= REQUEST;
            selB  <= 1'b1;
          end else begin
            state <= IDLE;
          end
        end
        REQUEST:    if (outAck) state <= LOAD;
        default:    state <= IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.captAddr = (state == IDLE) && efStrobe;
    ctl.loadA    = (state == REQUEST) && outAck && !selB;
    ctl.loadB    = (state == REQUEST) && outAck && selB;
    dataReq      = (state == REQUEST);
  end
endmodule

// File: rtl/dac_front_decode.sv
module dac_front_decode (
  input  logic       trigMode,
  input  logic       sign1,
  input  logic       sign2,
  output logic [1:0] quad,
  output logic [3:0] refSel
);
  always_comb begin
    quad = 2'd0;
    if (trigMode) begin
      case ({sign1, sign2})
        2'b00:   quad = 2'd0;
        2'b01:   quad = 2'd1;
        2'b11:   quad = 2'd2;
        default: quad = 2'd3;
      endcase
    end
    refSel = {trigMode, sign2, trigMode, sign1};
  end
endmodule

// File: rtl/dac_front_dp.sv
module dac_front_dp
  import dac_front_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  dpCtl_t             ctl,
  input  logic [ADDR_W-1:0]  ctlWord,
  input  logic [ADDR_W-1:0]  chanAAddr,
  input  logic [ADDR_W-1:0]  chanBAddr,
  input  logic [WORD_W-1:0]  dataWord,
  input  logic               trigMode,
  output logic               hitA,
  output logic               hitB,
  output logic [1:0][1:0][FIELD_W-1:0] holdReg,
  output logic [1:0][1:0]    quad,
  output logic [1:0][3:0]    refSel
);
  localparam int SIGN_BIT = FIELD_W - 1;

  logic [ADDR_W-1:0] addrReg;

  always_ff @(posedge clk) begin
    if (rst)               addrReg <= '0;
    else if (ctl.captAddr) addrReg <= ctlWord;
  end

  assign hitA = (addrReg == chanAAddr);
  assign hitB = (addrReg == chanBAddr);

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic chLoad;
    assign chLoad = (ch == 0) ? ctl.loadA : ctl.loadB;

    always_ff @(posedge clk) begin
      if (rst) begin
        holdReg[ch] <= '0;
      end else if (chLoad) begin
        holdReg[ch][0] <= dataWord[WORD_W-1:FIELD_W];
        holdReg[ch][1] <= dataWord[FIELD_W-1:0];
      end
    end

    dac_front_decode u_dec (
      .trigMode (trigMode),
      .sign1    (holdReg[ch][0][SIGN_BIT]),
      .sign2    (holdReg[ch][1][SIGN_BIT]),
      .quad     (quad[ch]),
      .refSel   (refSel[ch])
    );
  end
endmodule

// File: rtl/dac_front_ctl.sv
module dac_front_ctl
  import dac_front_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               efStrobe,
  input  logic [ADDR_W-1:0]  ctlWord,
  input  logic [ADDR_W-1:0]  chanAAddr,
  input  logic [ADDR_W-1:0]  chanBAddr,
  input  logic               outAck,
  input  logic [WORD_W-1:0]  dataWord,
  input  logic               trigMode,
  output logic               dataReq,
  output logic [FIELD_W-1:0] aSub1,
  output logic [FIELD_W-1:0] aSub2,
  output logic [FIELD_W-1:0] bSub1,
  output logic [FIELD_W-1:0] bSub2,
  output logic [1:0]         aQuad,
  output logic [1:0]         bQuad,
  output logic [3:0]         aRefSel,
  output logic [3:0]         bRefSel
);
  dpCtl_t ctl;
  logic   hitA, hitB;
  logic [1:0][1:0][FIELD_W-1:0] holdReg;
  logic [1:0][1:0] quad;
  logic [1:0][3:0] refSel;

  dac_front_hs u_hs (
    .clk(clk), .rst(rst), .efStrobe(efStrobe), .outAck(outAck),
    .hitA(hitA), .hitB(hitB), .ctl(ctl), .dataReq(dataReq)
  );

  dac_front_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .ctlWord(ctlWord),
    .chanAAddr(chanAAddr), .chanBAddr(chanBAddr), .dataWord(dataWord),
    .trigMode(trigMode), .hitA(hitA), .hitB(hitB),
    .holdReg(holdReg), .quad(quad), .refSel(refSel)
  );

  assign aSub1   = holdReg[0][0];
  assign aSub2   = holdReg[0][1];
  assign bSub1   = holdReg[1][0];
  assign bSub2   = holdReg[1][1];
  assign aQuad   = quad[0];
  assign bQuad   = quad[1];
  assign aRefSel = refSel[0];
  assign bRefSel = refSel[1];
endmodule

// File: rtl/dac_front_chk.sv
module dac_front_chk
  import dac_front_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               efStrobe,
  input logic [ADDR_W-1:0]  ctlWord,
  input logic [ADDR_W-1:0]  chanAAddr,
  input logic [ADDR_W-1:0]  chanBAddr,
  input logic               outAck,
  input logic               trigMode,
  input logic               dataReq,
  input logic [FIELD_W-1:0] aSub1,
  input logic [FIELD_W-1:0] aSub2,
  input logic [FIELD_W-1:0] bSub1,
  input logic [FIELD_W-1:0] bSub2,
  input logic [1:0]         aQuad,
  input logic [1:0]         bQuad
);
  AST_REQ_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(dataReq) |-> $past(efStrobe, 2)); // R3

  AST_REQ_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(dataReq) |-> ($past(ctlWord, 2) == chanAAddr || $past(ctlWord, 2) == chanBAddr)); // R3

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (dataReq && outAck) |=> !dataReq); // R4

  AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    !(dataReq && outAck) |=> ($stable(aSub1) && $stable(aSub2) && $stable(bSub1) && $stable(bSub2))); // R4

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    (dataReq && outAck) |=> (($stable(aSub1) && $stable(aSub2)) || ($stable(bSub1) && $stable(bSub2)))); // R6

  AST_LIN_QUAD: assert property (@(posedge clk) disable iff (rst)
    !trigMode |-> (aQuad == 2'd0 && bQuad == 2'd0)); // R9
endmodule

bind dac_front_ctl dac_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .efStrobe(efStrobe), .ctlWord(ctlWord),
  .chanAAddr(chanAAddr), .chanBAddr(chanBAddr), .outAck(outAck),
  .trigMode(trigMode), .dataReq(dataReq), .aSub1(aSub1), .aSub2(aSub2),
  .bSub1(bSub1), .bSub2(bSub2), .aQuad(aQuad), .bQuad(bQuad)
);

// File: tb/sim_dac_front_ctl.sv
module sim_dac_front_ctl;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic efStrobe = 1'b0;
  logic [AW-1:0] ctlWord = '0, chanAAddr = 6'h11, chanBAddr = 6'h22;
  logic outAck = 1'b0;
  logic [25:0] dataWord = '0;
  logic trigMode = 1'b1;
  logic dataReq;
  logic [12:0] aSub1, aSub2, bSub1, bSub2;
  logic [1:0] aQuad, bQuad;
  logic [3:0] aRefSel, bRefSel;

  always #4 clk = ~clk;

  dac_front_ctl #(.ADDR_W(AW)) u0 (.*);

  int nChecks = 0, nFails = 0;
  logic [51:0] expQ[$];
  logic [12:0] mA1 = '0, mA2 = '0, mB1 = '0, mB2 = '0;
  logic prevReq = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compare holding registers after each request falls (R5 R6)
  always @(negedge clk) begin
    if (!rst && prevReq && !dataReq) begin
      if (expQ.size() == 0) chk("R5_R6 unexpected", 64'd1, 64'd0);
      else chk("R5_R6 holding", {aSub1, aSub2, bSub1, bSub2}, expQ.pop_front());
    end
    prevReq = dataReq;
  end

  task automatic strobe(input logic [AW-1:0] addr);
    @(negedge clk); efStrobe = 1'b1; ctlWord = addr;
    @(negedge clk); efStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic ackData(input logic [25:0] d, input bit toB);
    if (toB) begin mB1 = d[25:13]; mB2 = d[12:0]; end
    else     begin mA1 = d[25:13]; mA2 = d[12:0]; end
    expQ.push_back({mA1, mA2, mB1, mB2});
    dataWord = d; outAck = 1'b1;
    @(negedge clk); outAck = 1'b0;
    chk("R4 req drop", dataReq, 1'b0);
  endtask

  task automatic writeWord(input logic [AW-1:0] addr, input logic [25:0] d,
                           input bit hit, input bit toB);
    strobe(addr);
    chk("R3 request", dataReq, hit);
    if (hit) ackData(d, toB);
    else begin @(negedge clk); chk("R3 no request", dataReq, 1'b0); end
  endtask

  function automatic logic [1:0] expQuad(input logic s, input logic c, input logic tm);
    if (!tm) return 2'd0;
    if (!s && !c) return 2'd0;
    if (!s && c)  return 2'd1;
    if (s && c)   return 2'd2;
    return 2'd3;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset regs", {aSub1, aSub2, bSub1, bSub2}, '0);
    chk("R1 reset req", dataReq, 1'b0);
    rst = 1'b0;

    // R2: address without strobe
    @(negedge clk); ctlWord = chanAAddr;
    repeat (4) @(negedge clk);
    chk("R2 no strobe", dataReq, 1'b0);

    // R5: field split into channel A
    writeWord(chanAAddr, {1'b0, 12'h123, 1'b1, 12'h456}, 1, 0);
    chk("R8 A quad", aQuad, expQuad(1'b0, 1'b1, 1'b1));
    chk("R9 A refsel trig", aRefSel, 4'b1110);

    // R8 all sign combinations on channel B; R6 A stays intact via scoreboard
    for (int k = 0; k < 4; k++) begin
      logic s, c;
      s = k[1]; c = k[0];
      writeWord(chanBAddr, {s, 12'hA00 + 12'(k), c, 12'h0F0 + 12'(k)}, 1, 1);
      chk("R8 B quad", bQuad, expQuad(s, c, 1'b1));
      chk("R6 A kept", {aSub1, aSub2}, {mA1, mA2});
    end

    // R3: unmatched address
    writeWord(6'h33, 26'h3FFFFFF, 0, 0);

    // R4: acknowledge without request
    @(negedge clk); dataWord = 26'h2AAAAAA; outAck = 1'b1;
    repeat (2) @(negedge clk); outAck = 1'b0;
    @(negedge clk);
    chk("R4 idle ack ignored", {aSub1, aSub2, bSub1, bSub2}, {mA1, mA2, mB1, mB2});
    chk("R4 idle ack no req", dataReq, 1'b0);

    // R7: second strobe while request pending
    strobe(chanAAddr);
    chk("R7 request", dataReq, 1'b1);
    efStrobe = 1'b1; ctlWord = chanBAddr;
    @(negedge clk); efStrobe = 1'b0;
    chk("R7 still pending", dataReq, 1'b1);
    ackData({1'b1, 12'h777, 1'b0, 12'h888}, 0);
    repeat (4) @(negedge clk);
    chk("R7 no extra request", dataReq, 1'b0);
    chk("R7 B untouched", {bSub1, bSub2}, {mB1, mB2});

    // R9: linear mode
    trigMode = 1'b0;
    @(negedge clk);
    chk("R9 A quad linear", aQuad, 2'd0);
    chk("R9 B quad linear", bQuad, 2'd0);
    chk("R9 A refsel linear", aRefSel, {1'b0, mA2[12], 1'b0, mA1[12]});
    chk("R9 B refsel linear", bRefSel, {1'b0, mB2[12], 1'b0, mB1[12]});

    // R10: equal addresses favour channel A
    chanBAddr = chanAAddr;
    writeWord(chanAAddr, {1'b0, 12'h0AB, 1'b0, 12'h0CD}, 1, 0);
    @(negedge clk);
    chk("R10 A priority", {aSub1, aSub2, bSub1, bSub2}, {mA1, mA2, mB1, mB2});

    chk("R5 scoreboard drained", 64'(expQ.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule